// File: doc/BRIEF.md
# Event Group Selection Matrix

This block connects raw event lines to general performance counters. The event lines form a two-dimensional array. There are several group columns, and each column holds one line for every possible event code. A shared selection register holds one code field per group column and a global enable bit. Each counter has a type register that names one group column. While the selection is enabled, the counter counts whichever code that column currently selects.

Because there is one code field per column, two counters that name the same column always count the same event. Software picks an event by its 12-bit identifier: the code in bits 11:4 and the column in bits 3:0. It can issue a column update with that identifier. The update replaces only that column's code field and turns the enable on. Software can also write the whole selection register at once. The type registers and the selection register are written and read through a simple address/data port. Every increment output is registered, so all counters see the same single cycle of latency.

Top module: `evsel_matrix`

## Requirements
- R1: After reset, the selection register (address 0x410) reads 0 with the enable bit (bit 63) clear, every type register reads 0, and every `ctr_inc` bit is 0.
- R2: A port write to 0x410 stores all 64 bits of `reg_wdata`. A read of 0x410 returns the stored value in the cycle after the write.
- R3: A column update with identifier `upd_event` behaves as follows. Bits 11:4 give the code and bits 3:0 give the column g. When g is below 8, the update writes the code into bits 8g+7..8g and sets bit 63. All other bits keep their values.
- R4: A column update whose column field is 8 or above leaves the selection register unchanged. The cycle-counter identifier 0x0FE is one such case.
- R5: Counter n has a type register at address 0x424 + 0x10·n. A write stores `reg_wdata[3:0]`. A read returns that value zero-extended to 64 bits.
- R6: Let g be the type value of counter n, and let c be the code field of column g. While bit 63 is set and g is below 8, `ctr_inc[n]` in cycle t+1 equals `event_in[c*8+g]` as sampled in cycle t.
- R7: While bit 63 of the selection register is clear, every `ctr_inc` bit is 0 in the next cycle.
- R8: A counter whose type value is 8 or above never increments, whatever the event lines carry.
- R9: Two counters with equal type values produce identical `ctr_inc` bits.
- R10: A port write to 0x410 and a column update can arrive in the same cycle. In that case only the port write takes effect.
- R11: The top bit of column 7's code field is the enable bit. After a column 7 update, the enable bit is set, so the code that takes effect is the written code with its top bit forced to 1. For example, identifier 0x057 makes column 7 select code 0x85.
- R12: A write to an address that is neither 0x410 nor a type register changes nothing. A read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register address for both read and write |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr`, combinational |
| upd_en | input | 1 | Column update strobe |
| upd_event | input | 12 | Event identifier for the update: code in [11:4], column in [3:0] |
| event_in | input | 2048 | Raw event lines; line (code, column) sits at index code*8+column |
| ctr_inc | output | 8 | Registered increment pulse, one bit per counter |

## Verification
A behavioural model in the bench predicts the increments and the read data on every clock. Single-hot event patterns show that a counter follows exactly the selected line of its own column. All-ones patterns show that the enable bit and out-of-range types really block counting, rather than a line simply being idle. Column 7 patterns place a hot line at both the written code and the code with its top bit forced. These two patterns tell the forced top bit apart from the plain written code. Long random runs that mix event words, identifiers and type writes confirm that updates leave the other code fields untouched.

// File: rtl/evsel_pkg.sv
package evsel_pkg;
    localparam int unsigned EVSEL_GROUPS     = 8;
    localparam int unsigned EVSEL_CODE_W     = 8;
    localparam int unsigned EVSEL_ID_GRP_W   = 4;
    localparam int unsigned EVSEL_TYPE_W     = 4;
    localparam int unsigned EVSEL_ADDR_W     = 12;
    localparam int unsigned EVSEL_CTRS       = 8;
    localparam int unsigned EVSEL_SEL_ADDR   = 'h410;
    localparam int unsigned EVSEL_TYPE_BASE  = 'h424;
    localparam int unsigned EVSEL_TYPE_STEP  = 'h10;

    function automatic int unsigned type_reg_addr(input int unsigned base,
                                                  input int unsigned step,
                                                  input int unsigned idx);
        return base + step * idx;
    endfunction
endpackage

// File: rtl/evsel_regs.sv
module evsel_regs
    import evsel_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = EVSEL_GROUPS,
    parameter int unsigned CODE_W     = EVSEL_CODE_W,
    parameter int unsigned ID_GRP_W   = EVSEL_ID_GRP_W,
    parameter int unsigned TYPE_W     = EVSEL_TYPE_W,
    parameter int unsigned ADDR_W     = EVSEL_ADDR_W,
    parameter int unsigned NUM_CTRS   = EVSEL_CTRS,
    parameter int unsigned SEL_ADDR   = EVSEL_SEL_ADDR,
    parameter int unsigned TYPE_BASE  = EVSEL_TYPE_BASE,
    parameter int unsigned TYPE_STEP  = EVSEL_TYPE_STEP,
    localparam int unsigned SEL_W     = NUM_GROUPS * CODE_W,
    localparam int unsigned ID_W      = CODE_W + ID_GRP_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [SEL_W-1:0]           wdata,
    output logic [SEL_W-1:0]           rdata,
    input  logic                       upd_en,
    input  logic [ID_W-1:0]            upd_id,
    output logic [SEL_W-1:0]           sel_o,
    output logic [NUM_CTRS*TYPE_W-1:0] types_o
);
    typedef struct packed {
        logic [SEL_W-1:0]                   sel;
        logic [NUM_CTRS-1:0][TYPE_W-1:0]    typ;
    } regs_t;

    regs_t st_d, st_q;

    logic                sel_hit;
    logic                grp_ok;
    logic [ID_GRP_W-1:0] upd_grp;
    logic [CODE_W-1:0]   upd_code;

    assign upd_grp  = upd_id[ID_GRP_W-1:0];
    assign upd_code = upd_id[ID_W-1:ID_GRP_W];
    assign sel_hit  = wr_en && (addr == ADDR_W'(SEL_ADDR));
    assign grp_ok   = int'(upd_grp) < NUM_GROUPS;

    // next-state: full write has priority over a column update
    always_comb begin
        st_d = st_q;
        if (sel_hit) begin
            st_d.sel = wdata;
        end else if (upd_en && grp_ok) begin
            st_d.sel[int'(upd_grp)*CODE_W +: CODE_W] = upd_code;
            st_d.sel[SEL_W-1] = 1'b1;
        end
        for (int n = 0; n < int'(NUM_CTRS); n++) begin
            if (wr_en && addr == ADDR_W'(type_reg_addr(TYPE_BASE, TYPE_STEP, n))) begin
                st_d.typ[n] = wdata[TYPE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read mux: unmapped addresses return zero
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(SEL_ADDR)) rdata = st_q.sel;
        for (int n = 0; n < int'(NUM_CTRS); n++) begin
            if (addr == ADDR_W'(type_reg_addr(TYPE_BASE, TYPE_STEP, n))) begin
                rdata = SEL_W'(st_q.typ[n]);
            end
        end
    end

    assign sel_o   = st_q.sel;
    assign types_o = st_q.typ;

    AST_UPD_SETS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !sel_hit && grp_ok) |=> sel_o[SEL_W-1]); // R3
    AST_BAD_GROUP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !sel_hit && !grp_ok) |=> $stable(sel_o)); // R4
    AST_FULL_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hit |=> (sel_o == $past(wdata))); // R10
endmodule

// File: rtl/evsel_route.sv
module evsel_route
    import evsel_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = EVSEL_GROUPS,
    parameter int unsigned CODE_W     = EVSEL_CODE_W,
    parameter int unsigned TYPE_W     = EVSEL_TYPE_W,
    parameter int unsigned NUM_CTRS   = EVSEL_CTRS,
    localparam int unsigned SEL_W     = NUM_GROUPS * CODE_W,
    localparam int unsigned NUM_CODES = 1 << CODE_W,
    localparam int unsigned EV_W      = NUM_CODES * NUM_GROUPS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SEL_W-1:0]           sel_i,
    input  logic [NUM_CTRS*TYPE_W-1:0] types_i,
    input  logic [EV_W-1:0]            event_i,
    output logic [NUM_CTRS-1:0]        inc_o
);
    typedef struct packed {
        logic [NUM_CTRS-1:0] inc;
    } route_t;

    route_t rt_d, rt_q;

    logic [NUM_GROUPS-1:0] col_hit;
    logic [NUM_CTRS-1:0]   lane_hit;

    // one code mux per column, shared by every counter
    for (genvar g = 0; g < int'(NUM_GROUPS); g++) begin : g_col
        logic [CODE_W-1:0] code;
        assign code       = sel_i[g*CODE_W +: CODE_W];
        assign col_hit[g] = event_i[int'(code)*NUM_GROUPS + g];
    end

    // per-counter column pick
    for (genvar n = 0; n < int'(NUM_CTRS); n++) begin : g_lane
        logic [TYPE_W-1:0] grp;
        logic              grp_ok;
        logic              hit;
        assign grp    = types_i[n*TYPE_W +: TYPE_W];
        assign grp_ok = int'(grp) < NUM_GROUPS;
        always_comb begin
            hit = 1'b0;
            if (grp_ok) hit = col_hit[int'(grp)];
        end
        assign lane_hit[n] = hit;

        AST_BAD_TYPE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            !grp_ok |=> !inc_o[n]); // R8

        if (n + 1 < int'(NUM_CTRS)) begin : g_pair
            AST_SAME_GROUP_SAME_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
                (grp == types_i[(n+1)*TYPE_W +: TYPE_W]) |=> (inc_o[n] == inc_o[n+1])); // R9
        end
    end

    always_comb begin
        rt_d.inc = lane_hit & {NUM_CTRS{sel_i[SEL_W-1]}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rt_q <= '0;
        else        rt_q <= rt_d;
    end

    assign inc_o = rt_q.inc;
endmodule

// File: rtl/evsel_matrix.sv
module evsel_matrix
    import evsel_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = EVSEL_GROUPS,
    parameter int unsigned CODE_W     = EVSEL_CODE_W,
    parameter int unsigned ID_GRP_W   = EVSEL_ID_GRP_W,
    parameter int unsigned TYPE_W     = EVSEL_TYPE_W,
    parameter int unsigned ADDR_W     = EVSEL_ADDR_W,
    parameter int unsigned NUM_CTRS   = EVSEL_CTRS,
    localparam int unsigned SEL_W     = NUM_GROUPS * CODE_W,
    localparam int unsigned ID_W      = CODE_W + ID_GRP_W,
    localparam int unsigned EV_W      = (1 << CODE_W) * NUM_GROUPS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [SEL_W-1:0]    reg_wdata,
    output logic [SEL_W-1:0]    reg_rdata,
    input  logic                upd_en,
    input  logic [ID_W-1:0]     upd_event,
    input  logic [EV_W-1:0]     event_in,
    output logic [NUM_CTRS-1:0] ctr_inc
);
    logic [SEL_W-1:0]           sel_q;
    logic [NUM_CTRS*TYPE_W-1:0] types_q;

    evsel_regs #(
        .NUM_GROUPS(NUM_GROUPS), .CODE_W(CODE_W), .ID_GRP_W(ID_GRP_W),
        .TYPE_W(TYPE_W), .ADDR_W(ADDR_W), .NUM_CTRS(NUM_CTRS)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .upd_en(upd_en), .upd_id(upd_event),
        .sel_o(sel_q), .types_o(types_q)
    );

    evsel_route #(
        .NUM_GROUPS(NUM_GROUPS), .CODE_W(CODE_W),
        .TYPE_W(TYPE_W), .NUM_CTRS(NUM_CTRS)
    ) route_i (
        .clk(clk), .rst_n(rst_n),
        .sel_i(sel_q), .types_i(types_q), .event_i(event_in), .inc_o(ctr_inc)
    );

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_q[SEL_W-1] |=> (ctr_inc == '0)); // R7
endmodule

// File: tb/evsel_matrix_tb_top.sv
`timescale 1ns/1ps
module evsel_matrix_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr_en = 1'b0;
    logic [11:0]  reg_addr = '0;
    logic [63:0]  reg_wdata = '0;
    logic [63:0]  reg_rdata;
    logic         upd_en = 1'b0;
    logic [11:0]  upd_event = '0;
    logic [2047:0] event_in = '0;
    logic [7:0]   ctr_inc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    evsel_matrix dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .upd_en(upd_en),
        .upd_event(upd_event), .event_in(event_in), .ctr_inc(ctr_inc)
    );

    // behavioural reference
    logic [63:0] m_sel = '0;
    logic [3:0]  m_typ [8];
    logic [7:0]  exp_inc = '0;

    function automatic logic [63:0] m_read(input logic [11:0] a);
        if (a == 12'h410) return m_sel;
        for (int n = 0; n < 8; n++)
            if (int'(a) == 'h424 + 'h10 * n) return {60'd0, m_typ[n]};
        return 64'd0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = '0;
            for (int n = 0; n < 8; n++) m_typ[n] = '0;
            exp_inc = '0;
        end else begin
            for (int n = 0; n < 8; n++) begin
                int g;
                g = int'(m_typ[n]);
                if (m_sel[63] && g < 8)
                    exp_inc[n] = event_in[int'(m_sel[g*8 +: 8])*8 + g];
                else
                    exp_inc[n] = 1'b0;
            end
            if (reg_wr_en && reg_addr == 12'h410) begin
                m_sel = reg_wdata;
            end else if (upd_en && upd_event[3:0] < 4'd8) begin
                m_sel[int'(upd_event[3:0])*8 +: 8] = upd_event[11:4];
                m_sel[63] = 1'b1;
            end
            for (int n = 0; n < 8; n++)
                if (reg_wr_en && int'(reg_addr) == 'h424 + 'h10 * n) m_typ[n] = reg_wdata[3:0];
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 increments vs model", {56'd0, ctr_inc}, {56'd0, exp_inc});
            chk("R2/R5/R12 read data vs model", reg_rdata, m_read(reg_addr));
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_wr_en = 1'b0;
    endtask

    task automatic upd(input logic [11:0] id);
        upd_en = 1'b1; upd_event = id;
        cyc();
        upd_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [63:0] v;
        repeat (3) cyc();
        rst_n = 1'b1;
        // R1 reset state
        rd(12'h410, v);  chk("R1 select after reset", v, 64'd0);
        rd(12'h434, v);  chk("R1 type after reset", v, 64'd0);
        chk("R1 increments after reset", {56'd0, ctr_inc}, 64'd0);

        // R2 full write, enable clear
        wr(12'h410, 64'h0123_4567_89AB_CDEF);
        rd(12'h410, v);  chk("R2 full write readback", v, 64'h0123_4567_89AB_CDEF);
        // R7 disabled: all lines high, nothing counts
        event_in = '1;
        cyc();
        chk("R7 disabled gives no increments", {56'd0, ctr_inc}, 64'd0);
        event_in = '0;

        // R3 column update code A5 into column 3
        upd(12'hA53);
        rd(12'h410, v);  chk("R3 column update merge", v, 64'h8123_4567_A5AB_CDEF);
        // R4 ignored identifiers
        upd(12'h0FE);
        rd(12'h410, v);  chk("R4 cycle identifier ignored", v, 64'h8123_4567_A5AB_CDEF);
        upd(12'h129);
        rd(12'h410, v);  chk("R4 column 9 ignored", v, 64'h8123_4567_A5AB_CDEF);

        // R5 type registers
        wr(12'h424, 64'd3);
        wr(12'h434, 64'd3);
        wr(12'h444, 64'hFFFF_FFFF_FFFF_FFF9);
        rd(12'h444, v);  chk("R5 type readback low bits", v, 64'd9);

        // R6 R9 single hot line at (A5, 3)
        event_in = '0;
        event_in[12'hA5 * 8 + 3] = 1'b1;
        cyc();
        chk("R6 R9 selected line counted", {56'd0, ctr_inc}, 64'h03);
        // R8 all lines high, counter 2 has type 9
        event_in = '1;
        cyc();
        chk("R8 out-of-range type silent", {56'd0, ctr_inc}, 64'hFB);
        event_in = '0;

        // R11 column 7 top bit shared with enable
        wr(12'h410, 64'd0);
        upd(12'h057);
        rd(12'h410, v);  chk("R11 column 7 forced top bit", v, 64'h8500_0000_0000_0000);
        wr(12'h454, 64'd7);
        event_in[12'h85 * 8 + 7] = 1'b1;
        cyc();
        chk("R11 code 0x85 counted", {56'd0, ctr_inc}, 64'h08);
        event_in = '0;
        event_in[12'h05 * 8 + 7] = 1'b1;
        cyc();
        chk("R11 code 0x05 not counted", {56'd0, ctr_inc}, 64'h00);
        event_in = '0;

        // R10 collision: full write wins
        reg_wr_en = 1'b1; reg_addr = 12'h410; reg_wdata = 64'h8000_0000_0000_0011;
        upd_en = 1'b1; upd_event = 12'h224;
        cyc();
        reg_wr_en = 1'b0; upd_en = 1'b0;
        rd(12'h410, v);  chk("R10 full write beats update", v, 64'h8000_0000_0000_0011);

        // R12 unmapped address
        wr(12'h500, '1);
        rd(12'h500, v);  chk("R12 unmapped reads zero", v, 64'd0);
        rd(12'h410, v);  chk("R12 unmapped write harmless", v, 64'h8000_0000_0000_0011);
        rd(12'h454, v);  chk("R12 type kept", v, 64'd7);

        // random phase, model compared every clock (R3 R6 R9)
        for (int i = 0; i < 600; i++) begin
            for (int w = 0; w < 64; w++) event_in[w*32 +: 32] = $urandom;
            upd_en = ($urandom % 4) == 0;
            upd_event = 12'($urandom % 4096);
            reg_wr_en = ($urandom % 6) == 0;
            reg_addr = 12'('h424 + 'h10 * ($urandom % 8));
            reg_wdata = 64'($urandom % 10);
            cyc();
        end
        reg_wr_en = 1'b0; upd_en = 1'b0;
        reg_addr = 12'h410;
        cyc();
        cyc();
        summary();
    end
endmodule